// File: doc/BRIEF.md
# Multi-Policy Float-to-Integer Converter

This block turns a floating-point register value, held in 64-bit double format, into a signed or unsigned integer of 32 or 64 bits. It is meant for a scalar execution pipe that moves conversion results from the floating-point side straight into an integer register. A 3-bit mode input picks one of three out-of-range policies:
- saturation, with NaN giving the type minimum;
- saturation, with NaN giving zero;
- modular wrap, with NaN and infinity giving zero.

Odd mode codes force truncation. Even codes take the rounding mode supplied with the operation.

The block has one register stage. An operation presented with `in_valid` shows its result, its write enable, its flags and its overflow indication on the following cycle. A narrowing input treats the operand as single precision first. An exception-enable input turns any invalid conversion into a suppressed write.

Top module: `fp2int_conv`

## Requirements
- R1: After reset every output is zero. An operation accepted with `in_valid` high appears on the outputs, with `out_valid` high, exactly one clock later. With `in_valid` low, `out_valid` and `wr_en` are low on the next cycle.
- R2: Rounding works as follows:
  - Odd `cvt_mode` codes (001, 011, 101) round toward zero.
  - Even codes use `fp_rnd`: 00 rounds to nearest with ties to even, 01 toward zero, 10 toward plus infinity and 11 toward minus infinity.
- R3: `cvt_mode` 000 to 011 saturate, and `int_kind` selects the type: 0 is signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit.
  - A rounded value above the type maximum returns the maximum, and one below the type minimum returns the minimum.
  - NaN returns the type minimum for 000/001 and zero for 010/011.
- R4: `cvt_mode` 100/101 wrap. NaN and infinity give zero. Any other value is rounded, and its two's-complement bits modulo 2^64 are kept, then reinterpreted as the selected type.
- R5: A signed 32-bit result is sign-extended from bit 31 to 64 bits. An unsigned 32-bit result has bits 63:32 at zero.
- R6: `overflow` is high when the source is NaN or infinity, or when the written integer differs in value from the source (fraction dropped, saturated or wrapped). Otherwise it is low.
- R7: Flags:
  - `flag_invalid` is set for NaN, for an out-of-range value under a saturating policy, and for infinity under the wrap policy.
  - `flag_snan` is set for a NaN whose quiet bit (fraction bit 51) is zero.
  - `flag_inexact` is set when a nonzero fraction is dropped and the conversion is not invalid.
- R8: With `inv_en` high, an invalid conversion drives `wr_en` low and the result to zero. `flag_inexact` and `overflow` are then low, and `flag_invalid` stays high.
- R9: With `narrow_sp` high, source fraction bits 28:0 take no part in the converted value. NaN and infinity detection still uses the full operand.
- R10: `cvt_mode` 110 and 111 raise `trap` with `wr_en` low, a zero result and all flags low, whatever the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| src_bits | input | 64 | Operand in double format |
| narrow_sp | input | 1 | Treat operand as single precision |
| int_kind | input | 2 | Target integer type |
| cvt_mode | input | 3 | Policy and truncation select |
| fp_rnd | input | 2 | Current rounding mode |
| inv_en | input | 1 | Invalid-operation exception enable |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Integer result |
| wr_en | output | 1 | Destination write enable |
| trap | output | 1 | Illegal mode code |
| flag_invalid | output | 1 | Invalid conversion |
| flag_snan | output | 1 | Signalling NaN operand |
| flag_inexact | output | 1 | Fraction discarded |
| overflow | output | 1 | Integer does not equal the source value |

## Verification
The sweep crosses every integer type, every legal mode and every rounding mode with about twenty operand magnitudes, each in both signs. The magnitudes include:
- quarter fractions and exact ties, which separate the four rounding directions;
- values a hair beyond 1/256 or a hair above one half, which exercise the sticky path;
- exact and just-over type boundaries (2^31, 2^32, 2^63, 2^64), which separate saturation from wrap and the signed types from the unsigned ones;
- huge powers of two, whose low 64 bits are zero under wrap.

Directed operands cover quiet and signalling NaN and both infinities under each policy. They also cover suppression with and without an invalid condition, narrowing of a value with low fraction bits set, and the two illegal mode codes.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int DW          = 64;
    localparam int EXP_W       = 11;
    localparam int FRAC_W      = 52;
    localparam int MAN_W       = FRAC_W + 1;
    localparam int BIAS        = 1023;
    localparam int NARROW_DROP = 29;
    localparam int SHIFT_W     = 13;
    localparam int SH_W        = $clog2(DW);

    typedef enum logic [1:0] {
        RM_NEAR  = 2'd0,
        RM_TRUNC = 2'd1,
        RM_UP    = 2'd2,
        RM_DOWN  = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        IT_S32 = 2'd0,
        IT_U32 = 2'd1,
        IT_S64 = 2'd2,
        IT_U64 = 2'd3
    } itype_e;

    typedef struct packed {
        logic                      sign;
        logic                      nan;
        logic                      snan;
        logic                      inf;
        logic [MAN_W-1:0]          man;
        logic signed [SHIFT_W-1:0] k;
    } fp_fields_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] result;
        logic          wr;
        logic          trap;
        logic          inv;
        logic          snan;
        logic          inexact;
        logic          ovf;
    } out_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [DW-1:0] src_i,
    input  logic          narrow_i,
    output fp_fields_t    f_o
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W-1:0] frac_n;
    logic              is_nan;

    always_comb begin
        expo   = src_i[DW-2 -: EXP_W];
        frac   = src_i[FRAC_W-1:0];
        frac_n = frac;
        if (narrow_i) begin
            frac_n[NARROW_DROP-1:0] = '0;
        end
        // class comes from the full operand, value from the narrowed one
        is_nan     = (&expo) & (|frac);
        f_o.sign   = src_i[DW-1];
        f_o.nan    = is_nan;
        f_o.inf    = (&expo) & ~(|frac);
        f_o.snan   = is_nan & ~frac[FRAC_W-1];
        f_o.man    = {(expo != '0), frac_n};
        f_o.k      = $signed({2'b00, ((expo == '0) ? EXP_W'(1) : expo)})
                   - $signed(SHIFT_W'(BIAS + FRAC_W));
    end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  logic                      sign_i,
    input  logic                      inf_i,
    input  logic [MAN_W-1:0]          man_i,
    input  logic signed [SHIFT_W-1:0] k_i,
    input  logic [1:0]                rmode_i,
    output logic [DW-1:0]             mag_o,
    output logic                      big_o,
    output logic                      frac_o
);
    localparam int WIDE_W = 2 * DW;
    localparam int FR_W   = MAN_W + DW;

    logic [WIDE_W-1:0]  wide;
    logic [FR_W-1:0]    fr_ext;
    logic [DW-1:0]      q;
    logic [SHIFT_W-1:0] rsh;
    logic [DW:0]        sum;
    logic               big, g, s, inc;

    always_comb begin
        wide   = '0;
        fr_ext = '0;
        q      = '0;
        rsh    = '0;
        big    = 1'b0;
        g      = 1'b0;
        s      = 1'b0;
        if (inf_i) begin
            big = 1'b1;
        end else if (!k_i[SHIFT_W-1]) begin
            // integer already: shift left, bits past 2^64 only mark "big"
            if ($signed(k_i) >= $signed(SHIFT_W'(DW))) begin
                big = 1'b1;
            end else begin
                wide = {{(WIDE_W-MAN_W){1'b0}}, man_i} << k_i[SH_W-1:0];
                q    = wide[DW-1:0];
                big  = |wide[WIDE_W-1:DW];
            end
        end else begin
            rsh = SHIFT_W'(-k_i);
            if (rsh > SHIFT_W'(MAN_W + 1)) begin
                s = |man_i;
            end else begin
                fr_ext = {man_i, {DW{1'b0}}} >> rsh;
                q      = DW'(fr_ext[FR_W-1:DW]);
                g      = fr_ext[DW-1];
                s      = |fr_ext[DW-2:0];
            end
        end
        case (rmode_e'(rmode_i))
            RM_NEAR:  inc = g & (s | q[0]);
            RM_TRUNC: inc = 1'b0;
            RM_UP:    inc = ~sign_i & (g | s);
            RM_DOWN:  inc = sign_i & (g | s);
            default:  inc = 1'b0;
        endcase
        sum    = {1'b0, q} + {{DW{1'b0}}, inc};
        mag_o  = sum[DW-1:0];
        big_o  = big | sum[DW];
        frac_o = g | s;
    end
endmodule

// File: rtl/fcvt_policy.sv
module fcvt_policy
    import fcvt_pkg::*;
(
    input  logic          sign_i,
    input  logic          nan_i,
    input  logic          inf_i,
    input  logic [DW-1:0] mag_i,
    input  logic          big_i,
    input  logic          frac_i,
    input  logic [1:0]    itype_i,
    input  logic          wrap_i,
    input  logic          nan_zero_i,
    output logic [DW-1:0] res_o,
    output logic          invalid_o,
    output logic          inexact_o,
    output logic          ovf_o
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] sv, ext, max_v, min_v;
    logic          hi, lo, out_rng;

    always_comb begin
        sv = sign_i ? (~mag_i + DW'(1)) : mag_i;
        case (itype_e'(itype_i))
            IT_S32: begin
                hi    = ~sign_i & (big_i | (|mag_i[DW-1:HALF-1]));
                lo    = sign_i & (big_i | (|mag_i[DW-1:HALF])
                        | (mag_i[HALF-1] & (|mag_i[HALF-2:0])));
                max_v = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
                min_v = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
                ext   = {{HALF{sv[HALF-1]}}, sv[HALF-1:0]};
            end
            IT_U32: begin
                hi    = ~sign_i & (big_i | (|mag_i[DW-1:HALF]));
                lo    = sign_i & (big_i | (|mag_i));
                max_v = {{HALF{1'b0}}, {HALF{1'b1}}};
                min_v = '0;
                ext   = {{HALF{1'b0}}, sv[HALF-1:0]};
            end
            IT_S64: begin
                hi    = ~sign_i & (big_i | mag_i[DW-1]);
                lo    = sign_i & (big_i | (mag_i[DW-1] & (|mag_i[DW-2:0])));
                max_v = {1'b0, {(DW-1){1'b1}}};
                min_v = {1'b1, {(DW-1){1'b0}}};
                ext   = sv;
            end
            default: begin
                hi    = ~sign_i & big_i;
                lo    = sign_i & (big_i | (|mag_i));
                max_v = '1;
                min_v = '0;
                ext   = sv;
            end
        endcase
        out_rng = hi | lo;

        if (wrap_i) begin
            res_o = (nan_i | inf_i) ? '0 : ext;
        end else if (nan_i) begin
            res_o = nan_zero_i ? '0 : min_v;
        end else if (hi) begin
            res_o = max_v;
        end else if (lo) begin
            res_o = min_v;
        end else begin
            res_o = ext;
        end

        invalid_o = nan_i | (~wrap_i & out_rng) | (wrap_i & inf_i);
        inexact_o = frac_i & ~nan_i & ~inf_i & ~(~wrap_i & out_rng);
        ovf_o     = nan_i | inf_i | frac_i | out_rng;
    end
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
    import fcvt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [63:0]   src_bits,
    input  logic          narrow_sp,
    input  logic [1:0]    int_kind,
    input  logic [2:0]    cvt_mode,
    input  logic [1:0]    fp_rnd,
    input  logic          inv_en,
    output logic          out_valid,
    output logic [63:0]   result,
    output logic          wr_en,
    output logic          trap,
    output logic          flag_invalid,
    output logic          flag_snan,
    output logic          flag_inexact,
    output logic          overflow
);
    fp_fields_t    fld;
    logic [1:0]    rm_eff;
    logic [DW-1:0] mag, pol_res;
    logic          big, frac, pol_inv, pol_inx, pol_ovf;
    logic          illegal, suppress;
    out_t          st_d, st_q;

    assign rm_eff  = cvt_mode[0] ? RM_TRUNC : fp_rnd;
    assign illegal = &cvt_mode[2:1];

    fcvt_unpack u_unpack (
        .src_i    (src_bits),
        .narrow_i (narrow_sp),
        .f_o      (fld)
    );

    fcvt_round u_round (
        .sign_i  (fld.sign),
        .inf_i   (fld.inf),
        .man_i   (fld.man),
        .k_i     (fld.k),
        .rmode_i (rm_eff),
        .mag_o   (mag),
        .big_o   (big),
        .frac_o  (frac)
    );

    fcvt_policy u_policy (
        .sign_i     (fld.sign),
        .nan_i      (fld.nan),
        .inf_i      (fld.inf),
        .mag_i      (mag),
        .big_i      (big),
        .frac_i     (frac),
        .itype_i    (int_kind),
        .wrap_i     (cvt_mode[2]),
        .nan_zero_i (cvt_mode[1]),
        .res_o      (pol_res),
        .invalid_o  (pol_inv),
        .inexact_o  (pol_inx),
        .ovf_o      (pol_ovf)
    );

    always_comb begin
        st_d     = '0;
        suppress = inv_en & pol_inv;
        if (in_valid) begin
            st_d.valid = 1'b1;
            if (illegal) begin
                st_d.trap = 1'b1;
            end else begin
                st_d.wr      = ~suppress;
                st_d.result  = suppress ? '0 : pol_res;
                st_d.inv     = pol_inv;
                st_d.snan    = fld.snan;
                st_d.inexact = ~suppress & pol_inx;
                st_d.ovf     = ~suppress & pol_ovf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign result       = st_q.result;
    assign wr_en        = st_q.wr;
    assign trap         = st_q.trap;
    assign flag_invalid = st_q.inv;
    assign flag_snan    = st_q.snan;
    assign flag_inexact = st_q.inexact;
    assign overflow     = st_q.ovf;
endmodule

// File: rtl/fp2int_conv_chk.sv
module fp2int_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] src_bits,
    input logic [1:0]  int_kind,
    input logic [2:0]  cvt_mode,
    input logic        inv_en,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        wr_en,
    input logic        trap,
    input logic        flag_invalid,
    input logic        flag_inexact,
    input logic        overflow
);
    logic src_nan, legal;
    assign src_nan = (&src_bits[62:52]) && (|src_bits[51:0]);
    assign legal   = (cvt_mode[2:1] != 2'b11);

    p_valid_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en));
    p_nan_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_nan && cvt_mode[2:1] == 2'b01 && !inv_en) |=> (result == '0));
    p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && int_kind == 2'd1) |=> (result[63:32] == '0));
    p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && int_kind == 2'd0) |=> (result[63:32] == {32{result[31]}}));
    p_inexact_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inexact |-> overflow);
    p_nan_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && src_nan) |=> flag_invalid);
    p_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && src_nan && inv_en) |=> (!wr_en && result == '0 && !overflow));
    p_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal) |=> (trap && !wr_en && !flag_invalid));
endmodule

bind fp2int_conv fp2int_conv_chk u_chk (.*);

// File: tb/fp2int_conv_tb.sv
`timescale 1ns/1ps
module fp2int_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] src_bits;
    logic        narrow_sp;
    logic [1:0]  int_kind;
    logic [2:0]  cvt_mode;
    logic [1:0]  fp_rnd;
    logic        inv_en;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_en, trap, flag_invalid, flag_snan, flag_inexact, overflow;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fp2int_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_bits(src_bits),
        .narrow_sp(narrow_sp), .int_kind(int_kind), .cvt_mode(cvt_mode),
        .fp_rnd(fp_rnd), .inv_en(inv_en), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .trap(trap), .flag_invalid(flag_invalid),
        .flag_snan(flag_snan), .flag_inexact(flag_inexact), .overflow(overflow)
    );

    localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;

    // value = +/- m * 2^s / 256, m below 2^53
    function automatic logic [63:0] enc(input bit sgn, input logic [63:0] m, input int s);
        int p;
        logic [63:0] sh;
        p = 0;
        for (int i = 0; i < 64; i++) if (m[i]) p = i;
        if (m == 64'd0) return {sgn, 63'd0};
        sh = m << (52 - p);
        return {sgn, 11'(1023 + p + s - 8), sh[51:0]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [63:0] eres, input logic einv,
                           input logic esn, input logic einx, input logic eovf,
                           input logic ewr, input logic etrap);
        check(tag, "valid",   64'(out_valid),    64'd1);
        check(tag, "result",  result,            eres);
        check(tag, "invalid", 64'(flag_invalid), 64'(einv));
        check(tag, "snan",    64'(flag_snan),    64'(esn));
        check(tag, "inexact", 64'(flag_inexact), 64'(einx));
        check(tag, "ovf",     64'(overflow),     64'(eovf));
        check(tag, "wr",      64'(wr_en),        64'(ewr));
        check(tag, "trap",    64'(trap),         64'(etrap));
    endtask

    task automatic apply(input logic [63:0] b, input logic nar, input int it,
                         input int md, input int rm, input logic ie);
        @(negedge clk);
        in_valid  = 1'b1;
        src_bits  = b;
        narrow_sp = nar;
        int_kind  = 2'(it);
        cvt_mode  = 3'(md);
        fp_rnd    = 2'(rm);
        inv_en    = ie;
        @(negedge clk);
    endtask

    task automatic ref_conv(input bit sgn, input logic [63:0] m, input int s,
                            input int it, input int md, input int rm,
                            output logic [63:0] eres, output logic einv,
                            output logic einx, output logic eovf);
        logic [191:0] a, q, mag;
        logic signed [191:0] r, mx, mn;
        logic [63:0] low, ext;
        int rem, eff;
        bit up, outr;
        a   = {128'd0, m} << s;
        q   = a >> 8;
        rem = int'(a[7:0]);
        eff = (md % 2 == 1) ? 1 : rm;
        case (eff)
            0: up = (rem > 128) || (rem == 128 && q[0]);
            1: up = 1'b0;
            2: up = !sgn && rem != 0;
            default: up = sgn && rem != 0;
        endcase
        mag = q + 192'(up);
        r   = sgn ? -$signed(mag) : $signed(mag);
        case (it)
            0: begin mx = (192'sd1 <<< 31) - 1; mn = -(192'sd1 <<< 31); end
            1: begin mx = (192'sd1 <<< 32) - 1; mn = 0; end
            2: begin mx = (192'sd1 <<< 63) - 1; mn = -(192'sd1 <<< 63); end
            default: begin mx = (192'sd1 <<< 64) - 1; mn = 0; end
        endcase
        outr = (r > mx) || (r < mn);
        low  = r[63:0];
        if (it == 0)      ext = {{32{low[31]}}, low[31:0]};
        else if (it == 1) ext = {32'd0, low[31:0]};
        else              ext = low;
        if (md >= 4) begin
            eres = ext;
            einv = 1'b0;
        end else begin
            if (r > mx)      eres = mx[63:0];
            else if (r < mn) eres = mn[63:0];
            else             eres = ext;
            einv = outr;
        end
        einx = (rem != 0) && !(md < 4 && outr);
        eovf = (rem != 0) || outr;
    endtask

    logic [63:0] tm [20];
    int          ts [20];

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] eres;
        logic einv, einx, eovf;
        string tag;

        tm[0]  = 64'd0;                      ts[0]  = 0;
        tm[1]  = 64'd64;                     ts[1]  = 0;
        tm[2]  = 64'd128;                    ts[2]  = 0;
        tm[3]  = 64'd192;                    ts[3]  = 0;
        tm[4]  = 64'd384;                    ts[4]  = 0;
        tm[5]  = 64'd640;                    ts[5]  = 0;
        tm[6]  = 64'd129;                    ts[6]  = 0;
        tm[7]  = 64'd1;                      ts[7]  = 0;
        tm[8]  = 64'h7FFF_FFFF;              ts[8]  = 8;
        tm[9]  = (64'd1 << 39) + 64'd128;    ts[9]  = 0;
        tm[10] = 64'hFF_FFFF_FFC0;           ts[10] = 0;
        tm[11] = 64'd1;                      ts[11] = 40;
        tm[12] = 64'd1;                      ts[12] = 71;
        tm[13] = (64'd1 << 52) | 64'd1;      ts[13] = 19;
        tm[14] = 64'd3;                      ts[14] = 70;
        tm[15] = 64'd1;                      ts[15] = 72;
        tm[16] = 64'd1;                      ts[16] = 108;
        tm[17] = 64'h1F_FFFF_FFFF_FFFF;      ts[17] = 8;
        tm[18] = 64'd1;                      ts[18] = 39;
        tm[19] = 64'h17F;                    ts[19] = 0;

        rst_n = 1'b0; in_valid = 1'b1; src_bits = QNAN; narrow_sp = 1'b0;
        int_kind = 2'd0; cvt_mode = 3'd0; fp_rnd = 2'd0; inv_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset outputs",
              {out_valid, wr_en, trap, flag_invalid, flag_snan, flag_inexact, overflow}, 64'd0);
        check("R1", "reset result", result, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle valid", 64'(out_valid), 64'd0);

        // R2 rounding directions
        apply(enc(0, 640, 0), 0, 0, 0, 0, 0); chk_all("R2 rne 2.5", 64'd2, 0, 0, 1, 1, 1, 0);
        apply(enc(0, 896, 0), 0, 0, 0, 0, 0); chk_all("R2 rne 3.5", 64'd4, 0, 0, 1, 1, 1, 0);
        apply(enc(1, 640, 0), 0, 2, 0, 2, 0); chk_all("R2 ceil -2.5", -64'sd2, 0, 0, 1, 1, 1, 0);
        apply(enc(1, 640, 0), 0, 2, 0, 3, 0); chk_all("R2 floor -2.5", -64'sd3, 0, 0, 1, 1, 1, 0);
        apply(enc(0, 896, 0), 0, 2, 1, 2, 0); chk_all("R2 odd mode truncates", 64'd3, 0, 0, 1, 1, 1, 0);

        // R3 / R4 / R7 special operands
        apply(QNAN, 0, 0, 0, 0, 0); chk_all("R3 R7 qnan min", 64'hFFFF_FFFF_8000_0000, 1, 0, 0, 1, 1, 0);
        apply(QNAN, 0, 3, 2, 0, 0); chk_all("R3 qnan zero", 64'd0, 1, 0, 0, 1, 1, 0);
        apply(SNAN, 0, 2, 1, 0, 0); chk_all("R7 snan min", 64'h8000_0000_0000_0000, 1, 1, 0, 1, 1, 0);
        apply(SNAN, 0, 1, 5, 0, 0); chk_all("R4 snan wrap", 64'd0, 1, 1, 0, 1, 1, 0);
        apply(PINF, 0, 2, 0, 0, 0); chk_all("R3 +inf max", 64'h7FFF_FFFF_FFFF_FFFF, 1, 0, 0, 1, 1, 0);
        apply(NINF, 0, 0, 3, 0, 0); chk_all("R3 -inf min", 64'hFFFF_FFFF_8000_0000, 1, 0, 0, 1, 1, 0);
        apply(PINF, 0, 1, 4, 0, 0); chk_all("R4 inf wrap", 64'd0, 1, 0, 0, 1, 1, 0);

        // R8 suppression
        apply(QNAN, 0, 0, 0, 0, 1); chk_all("R8 nan suppressed", 64'd0, 1, 0, 0, 0, 0, 0);
        apply(enc(0, (64'd1 << 40) + 64'd128, 0), 0, 0, 0, 0, 1);
        chk_all("R8 range suppressed", 64'd0, 1, 0, 0, 0, 0, 0);
        apply(enc(0, 384, 0), 0, 0, 0, 0, 1); chk_all("R8 valid not suppressed", 64'd2, 0, 0, 1, 1, 1, 0);

        // R9 narrowing
        apply(enc(0, (64'd1 << 52) | 64'd1, 8), 1, 2, 1, 0, 0);
        chk_all("R9 narrowed", 64'h0010_0000_0000_0000, 0, 0, 0, 0, 1, 0);
        apply(enc(0, (64'd1 << 52) | 64'd1, 8), 0, 2, 1, 0, 0);
        chk_all("R9 not narrowed", 64'h0010_0000_0000_0001, 0, 0, 0, 0, 1, 0);
        apply(SNAN, 1, 2, 0, 0, 0); chk_all("R9 nan kept", 64'h8000_0000_0000_0000, 1, 1, 0, 1, 1, 0);

        // R10 illegal modes
        apply(QNAN, 0, 0, 6, 0, 0); chk_all("R10 mode 6", 64'd0, 0, 0, 0, 0, 0, 1);
        apply(enc(0, 384, 0), 0, 3, 7, 0, 1); chk_all("R10 mode 7", 64'd0, 0, 0, 0, 0, 0, 1);

        // sweep: R2 R3 R4 R5 R6 R7
        for (int sg = 0; sg < 2; sg++)
            for (int i = 0; i < 20; i++)
                for (int it = 0; it < 4; it++)
                    for (int md = 0; md < 6; md++)
                        for (int rm = 0; rm < 4; rm++) begin
                            apply(enc(sg[0], tm[i], ts[i]), 0, it, md, rm, 0);
                            ref_conv(sg[0], tm[i], ts[i], it, md, rm, eres, einv, einx, eovf);
                            tag = $sformatf("%s %s R6 R7 v%0d s%0d t%0d m%0d r%0d",
                                            (md >= 4) ? "R4" : "R3", (it < 2) ? "R5" : "R2",
                                            i, sg, it, md, rm);
                            chk_all(tag, eres, einv, 1'b0, einx, eovf, 1'b1, 1'b0);
                        end

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "valid drops", {63'd0, out_valid}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule